// File: doc/BRIEF.md
# Configuration Space Access Decoder

This block sits behind a host processor and gives it the two-port configuration mechanism used to discover functions on an expansion bus. The host first writes a 32-bit configuration address to the address port. It then reads or writes the data port, and that access lands on the function and register that the latched address names. The block holds a small fixed table of emulated functions. Each entry is keyed by bus, device and function number and owns two 256-byte images. One is the configuration image the host normally sees. The other is a parallel image of base-address size masks.

Software sizes a base-address register by writing all ones to it and reading it back. The block recognises that probe: it stores nothing and raises a one-shot flag. While the flag is up, the next base-address read comes from the size-mask image. Absent functions answer with the patterns that enumeration software expects. A byte-order option serves big-endian hosts: it swaps the address word and reverses read data over the access length.

Requests are single-cycle pulses. Each read is answered exactly one cycle later. Writes produce no response.

Top module: `cfg_space_decoder`

## Requirements
- R1: The latched address is decoded as bus = bits 23:16, device = bits 15:11, function = bits 10:8 and register offset = bits 7:0. A data-port access targets the one table entry whose bus, device and function all match, and table keys are unique.
- R2: A data-port read with no matching entry returns 0xFFFFFFFF when the register offset is 0 and 0x00000000 at any other offset, for every access size and either byte order.
- R3: Read data is assembled little-endian from consecutive image bytes starting at the register offset. `req_size` code n selects n+1 bytes (0 gives 1 byte, 3 gives 4 bytes), and result bytes above the access length are zero.
- R4: A read whose last byte would fall beyond offset 255 returns 0.
- R5: A data-port write with size code 3 and value 0xFFFFFFFF, to a present function at a register offset from 0x10 through 0x24, sets the sizing flag and changes nothing. While the flag is set, a data-port read starting at an offset from 0x10 through 0x24 returns size-mask bytes. The flag is global: an address-port write in between does not clear it.
- R6: Every data-port read clears the sizing flag. A probe outside 0x10 through 0x24, or to an absent function, does not set it.
- R7: Data-port writes other than the probe leave the configuration image unchanged.
- R8: Word 0x04 of every image reads 0x00FFFFFF. Each base-address size mask at 0x10 through 0x24 reads 0x003FFFFF, except that the mask at 0x10 is set per entry.
- R9: With `host_be` high, a value written to the address port is byte-swapped across 32 bits before it is latched. Decode and readback both use the swapped value.
- R10: With `host_be` high, data read from a present function is byte-reversed over the access length. The absent-function patterns are not reversed.
- R11: A read of port 0 returns the latched address. Ports 2 and 3 read 0 and ignore writes.
- R12: `rsp_valid` is high exactly in the cycle after each read request, with `rsp_rdata` valid there, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_be | input | 1 | Host is big-endian: swap address writes and reverse read data |
| req_valid | input | 1 | Single-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 2 | 0 = address port, 1 = data port, 2 and 3 = unused |
| req_size | input | 2 | Access length minus one, in bytes |
| req_wdata | input | 32 | Write value |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read response data |

## Verification
The bench targets the sizing flag's lifetime. It probes a base-address register and checks that exactly one read sees the mask. A design that kept the flag would return masks on every later base-address read, and one that cleared it on an address write would show the stored base instead. It also probes at offsets just inside and outside the 0x10 to 0x24 window, and probes an absent function, which catches an off-by-one window or a flag raised without a match. Unaligned and narrow reads, a read running past offset 255, and big-endian accesses to both present and absent functions expose wrong lane selection, a missing range check, and reversal applied to the absent pattern or over the wrong length.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned BYTES_W = WORD_W / 8;
   localparam int unsigned KEY_W   = 16;

   localparam logic [7:0] BAR_FIRST = 8'h10;
   localparam logic [7:0] BAR_LAST  = 8'h24;
   localparam int unsigned NUM_BARS = (int'(BAR_LAST) - int'(BAR_FIRST)) / 4 + 1;

   localparam logic [WORD_W-1:0] ALL_ONES = '1;

   typedef enum logic [1:0] {
      PORT_ADDR = 2'd0,
      PORT_DATA = 2'd1,
      PORT_RSV2 = 2'd2,
      PORT_RSV3 = 2'd3
   } cfg_port_e;

   typedef struct packed {
      logic [7:0] hi_bits;
      logic [7:0] bus;
      logic [4:0] dev;
      logic [2:0] fn;
      logic [7:0] roff;
   } cfg_addr_t;

   function automatic logic [WORD_W-1:0] swap32(input logic [WORD_W-1:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   // Reverse the low (size+1) bytes of v; bytes above the access are zero.
   function automatic logic [WORD_W-1:0] rev_len(input logic [WORD_W-1:0] v,
                                                  input logic [1:0] size);
      logic [WORD_W-1:0] r;
      r = '0;
      for (int k = 0; k < BYTES_W; k++) begin
         if (k <= int'(size))
            r[k*8 +: 8] = v[(int'(size) - k)*8 +: 8];
      end
      return r;
   endfunction

   function automatic logic in_bar_window(input logic [7:0] roff);
      return (roff >= BAR_FIRST) && (roff <= BAR_LAST);
   endfunction

endpackage

// File: rtl/cfgd_match.sv
module cfgd_match
   import cfgd_pkg::*;
#(
   parameter int unsigned NUM_FUNCS = 3,
   parameter logic [NUM_FUNCS*KEY_W-1:0] FUNC_KEYS = '0
) (
   input  logic [KEY_W-1:0]     key,
   output logic [NUM_FUNCS-1:0] hit_vec,
   output logic                 hit
);

   for (genvar i = 0; i < NUM_FUNCS; i++) begin : g_cmp
      assign hit_vec[i] = (FUNC_KEYS[i*KEY_W +: KEY_W] == key);
   end

   assign hit = |hit_vec;

endmodule

// File: rtl/cfgd_image.sv
module cfgd_image
   import cfgd_pkg::*;
#(
   parameter int unsigned NUM_FUNCS = 3,
   parameter logic [NUM_FUNCS*WORD_W-1:0] FUNC_IDS       = '0,
   parameter logic [NUM_FUNCS*WORD_W-1:0] FUNC_CLASSES   = '0,
   parameter logic [NUM_FUNCS*WORD_W-1:0] FUNC_BAR0      = '0,
   parameter logic [NUM_FUNCS*WORD_W-1:0] FUNC_BAR0_MASK = '0,
   parameter logic [WORD_W-1:0] CMD_DEFAULT  = 32'h00FF_FFFF,
   parameter logic [WORD_W-1:0] MASK_DEFAULT = 32'h003F_FFFF
) (
   input  logic [NUM_FUNCS-1:0] hit_vec,
   input  logic [7:0]           roff,
   input  logic [1:0]           size,
   input  logic                 use_mask,
   output logic [WORD_W-1:0]    word_le
);

   localparam logic [5:0] W_ID    = 6'd0;
   localparam logic [5:0] W_CMD   = 6'd1;
   localparam logic [5:0] W_CLASS = 6'd2;
   localparam logic [5:0] W_BAR0  = BAR_FIRST[7:2];
   localparam logic [5:0] W_BARN  = BAR_LAST[7:2];

   logic [WORD_W-1:0] sel_id, sel_cls, sel_bar0, sel_mask0;
   logic [8:0]        end_off;
   logic              oob;
   logic [WORD_W-1:0] lanes;

   // AND-OR select of the matching entry's constants (keys are unique).
   always_comb begin
      sel_id    = '0;
      sel_cls   = '0;
      sel_bar0  = '0;
      sel_mask0 = '0;
      for (int i = 0; i < NUM_FUNCS; i++) begin
         if (hit_vec[i]) begin
            sel_id    |= FUNC_IDS[i*WORD_W +: WORD_W];
            sel_cls   |= FUNC_CLASSES[i*WORD_W +: WORD_W];
            sel_bar0  |= FUNC_BAR0[i*WORD_W +: WORD_W];
            sel_mask0 |= FUNC_BAR0_MASK[i*WORD_W +: WORD_W];
         end
      end
   end

   function automatic logic [WORD_W-1:0] cfg_word(input logic [5:0] widx,
                                                   input logic [WORD_W-1:0] id,
                                                   input logic [WORD_W-1:0] cls,
                                                   input logic [WORD_W-1:0] bar0);
      logic [WORD_W-1:0] w;
      case (widx)
         W_ID:    w = id;
         W_CMD:   w = CMD_DEFAULT;
         W_CLASS: w = cls;
         W_BAR0:  w = bar0;
         default: w = '0;
      endcase
      return w;
   endfunction

   function automatic logic [WORD_W-1:0] size_word(input logic [5:0] widx,
                                                    input logic [WORD_W-1:0] mask0);
      logic [WORD_W-1:0] w;
      if (widx == W_BAR0)
         w = mask0;
      else if (widx > W_BAR0 && widx <= W_BARN)
         w = MASK_DEFAULT;
      else
         w = '0;
      return w;
   endfunction

   assign end_off = {1'b0, roff} + {7'd0, size};
   assign oob     = end_off[8];

   for (genvar k = 0; k < BYTES_W; k++) begin : g_lane
      logic [8:0]        off;
      logic [WORD_W-1:0] src;
      assign off = {1'b0, roff} + 9'(k);
      assign src = use_mask ? size_word(off[7:2], sel_mask0)
                            : cfg_word(off[7:2], sel_id, sel_cls, sel_bar0);
      assign lanes[k*8 +: 8] = (k <= int'(size)) ? src[off[1:0]*8 +: 8] : 8'h00;
   end

   assign word_le = oob ? '0 : lanes;

endmodule

// File: rtl/cfgd_order.sv
module cfgd_order
   import cfgd_pkg::*;
#(
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic              host_be,
   input  logic [1:0]        size,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);

   if (SWAP_SUPPORT) begin : g_swap
      assign dout = host_be ? rev_len(din, size) : din;
   end else begin : g_pass
      logic unused_ok;
      assign unused_ok = host_be ^ (^size);
      assign dout = din;
   end

endmodule

// File: rtl/cfg_space_decoder.sv
module cfg_space_decoder
   import cfgd_pkg::*;
#(
   parameter int unsigned NUM_FUNCS = 3,
   parameter logic [NUM_FUNCS*KEY_W-1:0] FUNC_KEYS =
      {16'h011A, 16'h0018, 16'h0000},
   parameter logic [NUM_FUNCS*WORD_W-1:0] FUNC_IDS =
      {32'hCAFE_0042, 32'h5678_9ABC, 32'hA5A1_1234},
   parameter logic [NUM_FUNCS*WORD_W-1:0] FUNC_CLASSES =
      {32'h0300_0003, 32'h0101_8002, 32'h0600_0001},
   parameter logic [NUM_FUNCS*WORD_W-1:0] FUNC_BAR0 =
      {32'hE000_0000, 32'h0000_1001, 32'h0000_0000},
   parameter logic [NUM_FUNCS*WORD_W-1:0] FUNC_BAR0_MASK =
      {32'h00FF_FFFF, 32'h0000_00FF, 32'h003F_FFFF},
   parameter logic [WORD_W-1:0] CMD_DEFAULT  = 32'h00FF_FFFF,
   parameter logic [WORD_W-1:0] MASK_DEFAULT = 32'h003F_FFFF,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_be,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [1:0]  req_port,
   input  logic [1:0]  req_size,
   input  logic [31:0] req_wdata,
   output logic        rsp_valid,
   output logic [31:0] rsp_rdata
);

   localparam int unsigned MAX_FUNCS = 64;

   if (NUM_FUNCS < 1 || NUM_FUNCS > MAX_FUNCS) begin : g_bad_count
      $error("cfg_space_decoder: NUM_FUNCS out of range");
   end
   if (WORD_W != 32) begin : g_bad_width
      $error("cfg_space_decoder: data word must be 32 bits");
   end

   cfg_addr_t             addr_q;
   logic                  flag_q;
   logic                  rsp_valid_q;
   logic [WORD_W-1:0]     rsp_data_q;

   logic [NUM_FUNCS-1:0]  hit_vec;
   logic                  hit;
   logic                  rd_req, data_rd, probe, use_mask, bar_win;
   logic [WORD_W-1:0]     img_word, ordered, rd_value, addr_in;
   cfg_port_e             port;

   assign port    = cfg_port_e'(req_port);
   assign rd_req  = req_valid && !req_write;
   assign data_rd = rd_req && (port == PORT_DATA);
   assign bar_win = in_bar_window(addr_q.roff);

   assign probe = req_valid && req_write && (port == PORT_DATA) &&
                  (req_size == 2'd3) && (req_wdata == ALL_ONES) &&
                  hit && bar_win;

   assign use_mask = flag_q && bar_win;

   cfgd_match #(
      .NUM_FUNCS (NUM_FUNCS),
      .FUNC_KEYS (FUNC_KEYS)
   ) u_match (
      .key     ({addr_q.bus, addr_q.dev, addr_q.fn}),
      .hit_vec (hit_vec),
      .hit     (hit)
   );

   cfgd_image #(
      .NUM_FUNCS      (NUM_FUNCS),
      .FUNC_IDS       (FUNC_IDS),
      .FUNC_CLASSES   (FUNC_CLASSES),
      .FUNC_BAR0      (FUNC_BAR0),
      .FUNC_BAR0_MASK (FUNC_BAR0_MASK),
      .CMD_DEFAULT    (CMD_DEFAULT),
      .MASK_DEFAULT   (MASK_DEFAULT)
   ) u_image (
      .hit_vec  (hit_vec),
      .roff     (addr_q.roff),
      .size     (req_size),
      .use_mask (use_mask),
      .word_le  (img_word)
   );

   cfgd_order #(
      .SWAP_SUPPORT (SWAP_SUPPORT)
   ) u_order (
      .host_be (host_be),
      .size    (req_size),
      .din     (img_word),
      .dout    (ordered)
   );

   // Big-endian hosts present the address word byte-swapped.
   if (SWAP_SUPPORT) begin : g_addr_swap
      assign addr_in = host_be ? swap32(req_wdata) : req_wdata;
   end else begin : g_addr_pass
      assign addr_in = req_wdata;
   end

   always_comb begin
      case (port)
         PORT_ADDR: rd_value = addr_q;
         PORT_DATA: begin
            if (!hit)
               rd_value = (addr_q.roff == 8'h00) ? ALL_ONES : '0;
            else
               rd_value = ordered;
         end
         default:   rd_value = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q      <= '0;
         flag_q      <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= rd_req;
         if (rd_req)
            rsp_data_q <= rd_value;
         if (req_valid && req_write && port == PORT_ADDR)
            addr_q <= addr_in;
         if (probe)
            flag_q <= 1'b1;
         else if (data_rd)
            flag_q <= 1'b0;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = rsp_data_q;

endmodule

// File: rtl/cfg_space_decoder_chk.sv
module cfg_space_decoder_chk
   import cfgd_pkg::*;
#(
   parameter int unsigned NUM_FUNCS = 3,
   parameter logic [NUM_FUNCS*KEY_W-1:0] FUNC_KEYS = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_write,
   input logic [1:0]           req_port,
   input logic [1:0]           req_size,
   input logic [31:0]          req_wdata,
   input logic                 rsp_valid,
   input logic [31:0]          rsp_rdata,
   input logic [31:0]          addr_q,
   input logic                 flag_q,
   input logic [NUM_FUNCS-1:0] hit_vec
);

   logic rd_any, rd_data;
   logic [8:0] end_off;
   assign rd_any  = req_valid && !req_write;
   assign rd_data = rd_any && req_port == 2'd1;
   assign end_off = {1'b0, addr_q[7:0]} + {7'd0, req_size};

   initial begin
      for (int i = 0; i < NUM_FUNCS; i++) begin
         for (int j = i + 1; j < NUM_FUNCS; j++) begin
            a_r1_unique_keys: assert (FUNC_KEYS[i*KEY_W +: KEY_W] !=
                                      FUNC_KEYS[j*KEY_W +: KEY_W])
               else $error("duplicate bus/device/function key in table");
         end
      end
   end

   a_r1_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   a_r12_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_any |=> rsp_valid);

   a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_any |=> !rsp_valid);

   a_r11_addr_readback: assert property (@(posedge clk) disable iff (!rst_n)
      rd_any && req_port == 2'd0 |=> rsp_rdata == $past(addr_q));

   a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_any && req_port[1] |=> rsp_rdata == 32'h0);

   a_r6_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data |=> !flag_q);

   a_r5_flag_needs_probe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(req_valid && req_write && req_port == 2'd1 &&
                              req_size == 2'd3 && req_wdata == 32'hFFFF_FFFF));

   a_r4_past_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data && end_off[8] |=> rsp_rdata == 32'h0);

   a_r2_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data && hit_vec == '0 && addr_q[7:0] != 8'h00 |=> rsp_rdata == 32'h0);

   a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data && hit_vec != '0 && req_size == 2'd0 |=> rsp_rdata[31:8] == 24'h0);

endmodule

bind cfg_space_decoder cfg_space_decoder_chk #(
   .NUM_FUNCS (NUM_FUNCS),
   .FUNC_KEYS (FUNC_KEYS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_port  (req_port),
   .req_size  (req_size),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .addr_q    (addr_q),
   .flag_q    (flag_q),
   .hit_vec   (hit_vec)
);

// File: tb/cfg_space_decoder_bench.sv
`timescale 1ns/1ps
module cfg_space_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_be = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_port = 2'd0;
   logic [1:0]  req_size = 2'd3;
   logic [31:0] req_wdata = 32'h0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cfg_space_decoder u_cfg_space_decoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_be   (host_be),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_port  (req_port),
      .req_size  (req_size),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   // Table under test: E0 = bus0/dev0/fn0, E1 = bus0/dev3/fn0, E2 = bus1/dev3/fn2.
   localparam logic [31:0] A_E0 = 32'h0000_0000;
   localparam logic [31:0] A_E1 = 32'h0000_1800;
   localparam logic [31:0] A_E2 = 32'h0001_1A00;
   localparam logic [31:0] A_NONE = 32'h0001_1800;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [1:0] p, input logic [1:0] sz,
                         input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_port = p; req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic set_addr(input logic [31:0] a);
      access(1'b1, 2'd0, 2'd3, a);
   endtask

   task automatic rd(input logic [1:0] p, input logic [1:0] sz, output logic [31:0] v);
      access(1'b0, p, sz, 32'h0);
      check("R12 rsp_valid after read", {31'd0, rsp_valid}, 32'd1);
      v = rsp_rdata;
   endtask

   task automatic cfg_read(input logic [31:0] a, input logic [1:0] sz, output logic [31:0] v);
      set_addr(a);
      rd(2'd1, sz, v);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R12 rsp_valid low after reset", {31'd0, rsp_valid}, 32'd0);
      rd(2'd0, 2'd3, v);
      check("R11 address port reset value", v, 32'h0);
   endtask

   task automatic t_little_endian();
      logic [31:0] v;
      cfg_read(A_E1 | 32'h00, 2'd3, v); check("R3 E1 id word", v, 32'h5678_9ABC);
      cfg_read(A_E1 | 32'h02, 2'd1, v); check("R3 E1 two bytes at 2", v, 32'h0000_5678);
      cfg_read(A_E1 | 32'h01, 2'd0, v); check("R3 E1 one byte at 1", v, 32'h0000_009A);
      cfg_read(A_E1 | 32'h09, 2'd2, v); check("R3 E1 three bytes at 9", v, 32'h0001_0180);
      cfg_read(A_E0 | 32'h06, 2'd3, v); check("R3 E0 unaligned word at 6", v, 32'h0001_00FF);
      cfg_read(A_E2 | 32'h04, 2'd3, v); check("R8 E2 command/status default", v, 32'h00FF_FFFF);
      cfg_read(A_E2 | 32'h00, 2'd3, v); check("R1 E2 id selected by bus/dev/fn", v, 32'hCAFE_0042);
      cfg_read(A_E2 | 32'h10, 2'd3, v); check("R1 E2 base register 0", v, 32'hE000_0000);
   endtask

   task automatic t_absent();
      logic [31:0] v;
      cfg_read(A_NONE | 32'h00, 2'd3, v); check("R2 absent offset 0", v, 32'hFFFF_FFFF);
      cfg_read(A_NONE | 32'h08, 2'd3, v); check("R2 absent offset 8", v, 32'h0);
      cfg_read(32'h0000_1A00, 2'd0, v);   check("R1 R2 dev3/fn2 on bus0 absent", v, 32'hFFFF_FFFF);
   endtask

   task automatic t_past_end();
      logic [31:0] v;
      cfg_read(A_E1 | 32'hFE, 2'd3, v); check("R4 word crossing 255", v, 32'h0);
      cfg_read(A_E1 | 32'hFD, 2'd3, v); check("R4 word ending past 255", v, 32'h0);
   endtask

   task automatic t_probe();
      logic [31:0] v;
      set_addr(A_E1 | 32'h10);
      access(1'b1, 2'd1, 2'd3, 32'hFFFF_FFFF);
      rd(2'd1, 2'd3, v); check("R5 E1 size mask at 0x10", v, 32'h0000_00FF);
      rd(2'd1, 2'd3, v); check("R6 flag cleared after one read", v, 32'h0000_1001);
      set_addr(A_E1 | 32'h14);
      access(1'b1, 2'd1, 2'd3, 32'hFFFF_FFFF);
      rd(2'd1, 2'd3, v); check("R8 default mask at 0x14", v, 32'h003F_FFFF);
      set_addr(A_E1 | 32'h24);
      access(1'b1, 2'd1, 2'd3, 32'hFFFF_FFFF);
      rd(2'd1, 2'd3, v); check("R5 last window offset 0x24", v, 32'h003F_FFFF);
      set_addr(A_E1 | 32'h28);
      access(1'b1, 2'd1, 2'd3, 32'hFFFF_FFFF);
      cfg_read(A_E1 | 32'h10, 2'd3, v); check("R6 probe at 0x28 ignored", v, 32'h0000_1001);
      set_addr(A_E1 | 32'h10);
      access(1'b1, 2'd1, 2'd3, 32'hFFFF_FFFF);
      cfg_read(A_E1 | 32'h00, 2'd3, v); check("R6 non-window read returns id", v, 32'h5678_9ABC);
      cfg_read(A_E1 | 32'h10, 2'd3, v); check("R6 flag cleared by id read", v, 32'h0000_1001);
      set_addr(A_NONE | 32'h10);
      access(1'b1, 2'd1, 2'd3, 32'hFFFF_FFFF);
      cfg_read(A_E1 | 32'h10, 2'd3, v); check("R6 probe to absent function ignored", v, 32'h0000_1001);
      set_addr(A_E2 | 32'h10);
      access(1'b1, 2'd1, 2'd3, 32'hFFFF_FFFF);
      cfg_read(A_E1 | 32'h10, 2'd3, v); check("R5 flag survives address write", v, 32'h0000_00FF);
      set_addr(A_E2 | 32'h10);
      access(1'b1, 2'd1, 2'd3, 32'hFFFF_FFFF);
      set_addr(A_E2 | 32'h12);
      rd(2'd1, 2'd1, v); check("R5 narrow mask read at 0x12", v, 32'h0000_00FF);
   endtask

   task automatic t_no_store();
      logic [31:0] v;
      set_addr(A_E1 | 32'h00);
      access(1'b1, 2'd1, 2'd3, 32'h1234_5678);
      rd(2'd1, 2'd3, v); check("R7 id unchanged after write", v, 32'h5678_9ABC);
      set_addr(A_E1 | 32'h10);
      access(1'b1, 2'd1, 2'd1, 32'hFFFF_FFFF);
      rd(2'd1, 2'd3, v); check("R7 narrow all-ones write is no probe", v, 32'h0000_1001);
   endtask

   task automatic t_ports();
      logic [31:0] v;
      set_addr(32'h8001_1A3C);
      rd(2'd0, 2'd3, v); check("R11 address readback", v, 32'h8001_1A3C);
      rd(2'd2, 2'd3, v); check("R11 port 2 reads zero", v, 32'h0);
      access(1'b1, 2'd3, 2'd3, 32'hDEAD_BEEF);
      rd(2'd0, 2'd3, v); check("R11 port 3 write ignored", v, 32'h8001_1A3C);
      rd(2'd3, 2'd3, v); check("R11 port 3 reads zero", v, 32'h0);
   endtask

   task automatic t_big_endian();
      logic [31:0] v;
      host_be = 1'b1;
      set_addr(32'h0018_0000);
      rd(2'd0, 2'd3, v); check("R9 swapped address latched", v, A_E1);
      rd(2'd1, 2'd3, v); check("R10 reversed word", v, 32'hBC9A_7856);
      rd(2'd1, 2'd1, v); check("R10 reversed halfword", v, 32'h0000_BC9A);
      rd(2'd1, 2'd0, v); check("R10 single byte", v, 32'h0000_00BC);
      set_addr(32'h0018_0100);
      rd(2'd1, 2'd1, v); check("R10 absent pattern not reversed", v, 32'hFFFF_FFFF);
      host_be = 1'b0;
   endtask

   task automatic t_idle();
      repeat (2) @(negedge clk);
      check("R12 rsp_valid low when idle", {31'd0, rsp_valid}, 32'd0);
      access(1'b1, 2'd0, 2'd3, A_E0);
      check("R12 no response for write", {31'd0, rsp_valid}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_little_endian();
      t_absent();
      t_past_end();
      t_probe();
      t_no_store();
      t_ports();
      t_big_endian();
      t_idle();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule